// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two floating-point operands held in the wide internal register format and reduces the result to a four-bit N/Z/C/V flag nibble. An integer condition evaluator downstream consumes that nibble. The block also tests the nibble against a four-bit condition selector, so a caller gets both the raw flags and a ready-made taken/not-taken bit.

Each operand is a sign bit, a 15-bit biased exponent and a 64-bit mantissa. The mantissa carries an explicit units bit at its top. Three per-operation controls shape the compare:
- A negate option compares the first operand against the second operand with its sign inverted.
- An exception option makes quiet NaN operands raise invalid operation as well.
- A mode bit selects between two encodings of the unordered result.

Results are registered. They appear one cycle after the request, together with a single valid strobe.

Top module: `fpcmp_flags`

## Requirements
- R1: When the operands compare equal, flags_o (bit order N,Z,C,V from bit 3 down to bit 0) is 4'b0110.
- R2: When the first operand is less than the second, flags_o is 4'b1000.
- R3: When the first operand is greater than the second, flags_o is 4'b0010.
- R4: An operand is a NaN when its exponent is all ones and the 63 mantissa bits below the units bit are not all zero. When either operand is a NaN, the result is unordered. Unordered gives flags_o 4'b0001 when unord_mode_i is 0, and 4'b0011 when unord_mode_i is 1.
- R5: Positive and negative zero (exponent 0, mantissa 0) compare equal.
- R6: Ordering follows the signs, then the exponent, then the full 64-bit mantissa. For two negative operands the order is reversed. An infinity (exponent all ones, lower 63 mantissa bits zero, units bit ignored) is larger than every finite value of the same sign.
- R7: With negate_i set, the second operand's sign is inverted before the compare.
- R8: invalid_o is set when either operand is a signalling NaN, which is a NaN whose mantissa bit 62 is 0. It is also set for a quiet NaN (mantissa bit 62 is 1), but only when exc_cmp_i is 1. In all other cases invalid_o is clear.
- R9: cond_true_o evaluates cond_i against the registered flags. The codes are:

  | Code | Test |
  |------|------|
  | 0 | Z |
  | 1 | !Z |
  | 2 | C |
  | 3 | !C |
  | 4 | N |
  | 5 | !N |
  | 6 | V |
  | 7 | !V |
  | 8 | C&!Z |
  | 9 | !C\|Z |
  | 10 | N==V |
  | 11 | N!=V |
  | 12 | !Z&(N==V) |
  | 13 | Z\|(N!=V) |
  | 14 | always true |
  | 15 | never true |

- R10: valid_o rises in the cycle after a cycle with valid_i high, and is low after a cycle with valid_i low. After reset, valid_o, flags_o and invalid_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_a_i | input | 80 | First operand {sign, exponent, mantissa} |
| op_b_i | input | 80 | Second operand, same layout |
| negate_i | input | 1 | Compare against negated second operand |
| exc_cmp_i | input | 1 | Quiet NaNs also raise invalid |
| unord_mode_i | input | 1 | Unordered also sets C |
| cond_i | input | 4 | Condition selector |
| valid_o | output | 1 | Result strobe |
| flags_o | output | 4 | N,Z,C,V |
| cond_true_o | output | 1 | Selected condition holds |
| invalid_o | output | 1 | Invalid operation raised |

## Verification
The assertions take two things for granted:
- valid_i is low while reset is applied.
- Every finite operand is normalized: a nonzero finite value has its units bit set, and a zero has exponent 0 with mantissa 0.

Given those, each accepted compare must yield one of the five legal flag patterns, and an invalid result must be unordered. The stimulus builds every operand from a fixed set of classes that respect these rules: zero, normalized finite, infinity, quiet NaN, signalling NaN, and a copy of the other operand. It also keeps exponents clustered so that ties and mantissa-only differences occur often.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int OP_W  = 1 + EXP_W + MAN_W,
  localparam int KEY_W = EXP_W + MAN_W
) (
  input  logic [OP_W-1:0]  op_i,
  output logic             sign_o,
  output logic             nan_o,
  output logic             snan_o,
  output logic             zero_o,
  output logic [KEY_W-1:0] key_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max, frac_nz;

  assign sign_o  = op_i[OP_W-1];
  assign exp_f   = op_i[MAN_W +: EXP_W];
  assign man_f   = op_i[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign frac_nz = |man_f[MAN_W-2:0];
  assign nan_o   = exp_max & frac_nz;
  assign snan_o  = nan_o & ~man_f[MAN_W-2];
  assign zero_o  = (exp_f == '0) && (man_f == '0);
  // infinity ignores the units bit: flatten it to a single key
  assign key_o   = (exp_max && !frac_nz) ? {exp_f, {MAN_W{1'b0}}} : {exp_f, man_f};
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int KEY_W = 79
) (
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic             nan_a_i,
  input  logic             nan_b_i,
  input  logic             zero_a_i,
  input  logic             zero_b_i,
  input  logic [KEY_W-1:0] key_a_i,
  input  logic [KEY_W-1:0] key_b_i,
  output rel_e             rel_o
);
  logic mag_gt;

  always_comb begin
    mag_gt = key_a_i > key_b_i;
    if (nan_a_i || nan_b_i)        rel_o = REL_UN;
    else if (zero_a_i && zero_b_i) rel_o = REL_EQ;
    else if (sign_a_i != sign_b_i) rel_o = sign_a_i ? REL_LT : REL_GT;
    else if (key_a_i == key_b_i)   rel_o = REL_EQ;
    else if (mag_gt ^ sign_a_i)    rel_o = REL_GT;
    else                           rel_o = REL_LT;
  end
endmodule

// File: rtl/fpcmp_cond.sv
module fpcmp_cond
  import fpcmp_pkg::*;
(
  input  logic [3:0] flags_i,
  input  logic [3:0] cond_i,
  output logic       hit_o
);
  logic n, z, c, v;

  assign n = flags_i[FLAG_N];
  assign z = flags_i[FLAG_Z];
  assign c = flags_i[FLAG_C];
  assign v = flags_i[FLAG_V];

  always_comb begin
    unique case (cond_i)
      4'h0: hit_o = z;
      4'h1: hit_o = ~z;
      4'h2: hit_o = c;
      4'h3: hit_o = ~c;
      4'h4: hit_o = n;
      4'h5: hit_o = ~n;
      4'h6: hit_o = v;
      4'h7: hit_o = ~v;
      4'h8: hit_o = c & ~z;
      4'h9: hit_o = ~c | z;
      4'hA: hit_o = n == v;
      4'hB: hit_o = n != v;
      4'hC: hit_o = ~z & (n == v);
      4'hD: hit_o = z | (n != v);
      4'hE: hit_o = 1'b1;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int OP_W  = 1 + EXP_W + MAN_W,
  localparam int KEY_W = EXP_W + MAN_W,
  localparam int N_OP  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_a_i,
  input  logic [OP_W-1:0] op_b_i,
  input  logic            negate_i,
  input  logic            exc_cmp_i,
  input  logic            unord_mode_i,
  input  logic [3:0]      cond_i,
  output logic            valid_o,
  output logic [3:0]      flags_o,
  output logic            cond_true_o,
  output logic            invalid_o
);
  logic [N_OP-1:0] sgn, nan, snan, zero;
  logic [KEY_W-1:0] key [N_OP];
  rel_e             rel;
  logic [3:0]       flags_d, flags_q;
  logic             inv_d, inv_q, valid_q;
  logic [3:0]       cond_q;

  for (genvar g = 0; g < N_OP; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i   ((g == 0) ? op_a_i : op_b_i),
      .sign_o (sgn[g]),
      .nan_o  (nan[g]),
      .snan_o (snan[g]),
      .zero_o (zero[g]),
      .key_o  (key[g])
    );
  end

  fpcmp_order #(.KEY_W(KEY_W)) u_ord (
    .sign_a_i (sgn[0]),
    .sign_b_i (sgn[1] ^ negate_i),
    .nan_a_i  (nan[0]),
    .nan_b_i  (nan[1]),
    .zero_a_i (zero[0]),
    .zero_b_i (zero[1]),
    .key_a_i  (key[0]),
    .key_b_i  (key[1]),
    .rel_o    (rel)
  );

  always_comb begin
    unique case (rel)
      REL_EQ:  flags_d = 4'b0110;
      REL_LT:  flags_d = 4'b1000;
      REL_GT:  flags_d = 4'b0010;
      default: flags_d = {2'b00, unord_mode_i, 1'b1};
    endcase
  end

  assign inv_d = (|snan) | (exc_cmp_i & (|nan));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flags_q <= '0;
      inv_q   <= 1'b0;
      cond_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        flags_q <= flags_d;
        inv_q   <= inv_d;
        cond_q  <= cond_i;
      end
    end
  end

  fpcmp_cond u_cond (
    .flags_i (flags_q),
    .cond_i  (cond_q),
    .hit_o   (cond_true_o)
  );

  assign valid_o   = valid_q;
  assign flags_o   = flags_q;
  assign invalid_o = inv_q;
endmodule

// File: rtl/fpcmp_flags_chk.sv
module fpcmp_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       unord_mode_i,
  input logic [3:0] cond_i,
  input logic       valid_o,
  input logic [3:0] flags_o,
  input logic       cond_true_o,
  input logic       invalid_o
);
  logic       ac_s;
  logic [3:0] cond_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_s   <= 1'b0;
      cond_s <= '0;
    end else if (valid_i) begin
      ac_s   <= unord_mode_i;
      cond_s <= cond_i;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10
  AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R10
  AST_FLAGS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o == 4'b0110 || flags_o == 4'b1000 || flags_o == 4'b0010 ||
                 flags_o == 4'b0001 || flags_o == 4'b0011)); // R1
  AST_UNORD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[0]) |-> (flags_o[1] == ac_s)); // R4
  AST_INVALID_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && invalid_o) |-> flags_o[0]); // R8
  AST_COND_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cond_s == 4'hE) |-> cond_true_o); // R9
  AST_COND_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cond_s == 4'hF) |-> !cond_true_o); // R9
endmodule

bind fpcmp_flags fpcmp_flags_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .unord_mode_i (unord_mode_i),
  .cond_i       (cond_i),
  .valid_o      (valid_o),
  .flags_o      (flags_o),
  .cond_true_o  (cond_true_o),
  .invalid_o    (invalid_o)
);

// File: tb/sim_fpcmp_flags.sv
module sim_fpcmp_flags;
  localparam int OPW = 80;
  localparam time TCK = 20ns;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           valid_i = 1'b0;
  logic [OPW-1:0] op_a = '0, op_b = '0;
  logic           neg = 1'b0, exc = 1'b0, ac = 1'b0;
  logic [3:0]     cond = '0;
  logic           valid_o, cond_true_o, invalid_o;
  logic [3:0]     flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  fpcmp_flags u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .op_a_i(op_a), .op_b_i(op_b), .negate_i(neg), .exc_cmp_i(exc),
    .unord_mode_i(ac), .cond_i(cond),
    .valid_o(valid_o), .flags_o(flags_o), .cond_true_o(cond_true_o),
    .invalid_o(invalid_o)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [OPW-1:0] fp(input bit s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  function automatic bit is_nan(input logic [OPW-1:0] x);
    return (x[78:64] == 15'h7FFF) && (x[62:0] != '0);
  endfunction

  // 0 eq, 1 lt, 2 gt, 3 unordered
  function automatic int ref_rel(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input bit ng);
    bit sa, sb, za, zb, gt;
    logic [78:0] ka, kb;
    if (is_nan(a) || is_nan(b)) return 3;
    sa = a[79]; sb = b[79] ^ ng;
    za = a[78:0] == '0; zb = b[78:0] == '0;
    if (za && zb) return 0;
    if (sa != sb) return sa ? 1 : 2;
    ka = (a[78:64] == 15'h7FFF) ? {a[78:64], 64'd0} : a[78:0];
    kb = (b[78:64] == 15'h7FFF) ? {b[78:64], 64'd0} : b[78:0];
    if (ka == kb) return 0;
    gt = (ka > kb) != sa;
    return gt ? 2 : 1;
  endfunction

  function automatic logic [3:0] ref_flags(input int r, input bit m);
    case (r)
      0: return 4'b0110;
      1: return 4'b1000;
      2: return 4'b0010;
      default: return m ? 4'b0011 : 4'b0001;
    endcase
  endfunction

  function automatic bit ref_cond(input logic [3:0] f, input logic [3:0] c);
    bit n, z, cc, v;
    {n, z, cc, v} = f;
    case (c)
      0: return z;          1: return !z;
      2: return cc;         3: return !cc;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return cc && !z;   9: return !cc || z;
      10: return n == v;    11: return n != v;
      12: return !z && n == v;
      13: return z || n != v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_inv(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input bit e);
    bit sa = is_nan(a) && !a[62];
    bit sb = is_nan(b) && !b[62];
    return sa || sb || (e && (is_nan(a) || is_nan(b)));
  endfunction

  task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input bit ng,
                        input bit ex, input bit m, input logic [3:0] c, input string tag);
    int r;
    logic [3:0] ef;
    @(negedge clk);
    op_a = a; op_b = b; neg = ng; exc = ex; ac = m; cond = c; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    r  = ref_rel(a, b, ng);
    ef = ref_flags(r, m);
    check(valid_o === 1'b1, {tag, " R10 valid"}, {7'd0, valid_o}, 8'd1);
    check(flags_o === ef, {tag, " flags"}, {4'd0, flags_o}, {4'd0, ef});
    check(cond_true_o === ref_cond(ef, c), {tag, " R9 cond"}, {7'd0, cond_true_o}, {7'd0, ref_cond(ef, c)});
    check(invalid_o === ref_inv(a, b, ex), {tag, " R8 invalid"}, {7'd0, invalid_o}, {7'd0, ref_inv(a, b, ex)});
  endtask

  function automatic logic [OPW-1:0] rnd_op(input logic [OPW-1:0] other);
    logic [63:0] m;
    bit s = $urandom_range(0, 1);
    m = {1'b1, 31'($urandom), 32'($urandom)};
    if ($urandom_range(0, 1) == 1) m[31:0] = 32'($urandom_range(0, 3));
    case ($urandom_range(0, 7))
      0: return fp(s, 15'd0, 64'd0);
      1: return fp(s, 15'h7FFF, {1'($urandom_range(0, 1)), 63'd0});
      2: return fp(s, 15'h7FFF, {1'b1, 1'b1, m[61:0]});
      3: return fp(s, 15'h7FFF, {1'($urandom_range(0, 1)), 1'b0, m[61:1], 1'b1});
      4: return {s, other[78:0]};
      default: return fp(s, 15'(16'h3FFC + $urandom_range(0, 6)), m);
    endcase
  endfunction

  localparam logic [63:0] ONE_M = 64'h8000_0000_0000_0000;

  initial begin
    #(TCK * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [OPW-1:0] one, two, pz, nz, pinf, qn, sn;
    void'($urandom(32'h5eed_c0de));
    one  = fp(0, 15'h3FFF, ONE_M);
    two  = fp(0, 15'h4000, ONE_M);
    pz   = fp(0, 15'd0, 64'd0);
    nz   = fp(1, 15'd0, 64'd0);
    pinf = fp(0, 15'h7FFF, 64'd0);
    qn   = fp(0, 15'h7FFF, 64'hC000_0000_0000_0000);
    sn   = fp(0, 15'h7FFF, 64'h8000_0000_0000_0001);

    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && flags_o === 4'd0 && invalid_o === 1'b0, "R10 reset state",
          {2'd0, valid_o, invalid_o, flags_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(one, one, 0, 0, 0, 4'h0, "R1 equal");
    run_op(one, two, 0, 0, 0, 4'h4, "R2 less");
    run_op(two, one, 0, 0, 0, 4'h8, "R3 greater");
    run_op(qn, one, 0, 0, 0, 4'h6, "R4 unordered ac0");
    run_op(one, qn, 0, 0, 1, 4'h2, "R4 unordered ac1");
    run_op(pz, nz, 0, 0, 0, 4'h0, "R5 zero signs");
    run_op(nz, pz, 0, 0, 0, 4'hA, "R5 zero signs rev");
    run_op(one, fp(0, 15'h3FFF, ONE_M | 64'd1), 0, 0, 0, 4'h3, "R6 mantissa lsb");
    run_op(fp(1, 15'h3FFF, ONE_M), fp(1, 15'h4000, ONE_M), 0, 0, 0, 4'hC, "R6 negative order");
    run_op(pinf, fp(0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF), 0, 0, 0, 4'h8, "R6 inf largest");
    run_op(pinf, fp(0, 15'h7FFF, ONE_M), 0, 0, 0, 4'h0, "R6 inf units ignored");
    run_op(one, fp(1, 15'h3FFF, ONE_M), 1, 0, 0, 4'h0, "R7 negate equal");
    run_op(one, one, 1, 0, 0, 4'hC, "R7 negate greater");
    run_op(qn, one, 0, 0, 0, 4'h6, "R8 quiet no exc");
    run_op(qn, one, 0, 1, 0, 4'h6, "R8 quiet exc");
    run_op(one, sn, 0, 0, 1, 4'h6, "R8 signalling");

    @(negedge clk);
    check(valid_o === 1'b0, "R10 valid drops", {7'd0, valid_o}, 8'd0);

    for (int c = 0; c < 16; c++) begin
      run_op(one, one, 0, 0, 0, 4'(c), "R9 sweep eq");
      run_op(one, two, 0, 0, 0, 4'(c), "R9 sweep lt");
      run_op(two, one, 0, 0, 0, 4'(c), "R9 sweep gt");
      run_op(qn, one, 0, 0, 0, 4'(c), "R9 sweep un0");
      run_op(qn, one, 0, 0, 1, 4'(c), "R9 sweep un1");
    end

    for (int i = 0; i < 3000; i++) begin
      logic [OPW-1:0] a, b;
      bit ng;
      int r;
      a  = rnd_op(one);
      b  = rnd_op(a);
      ng = $urandom_range(0, 3) == 0;
      r  = ref_rel(a, b, ng);
      run_op(a, b, ng, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4'($urandom),
             r == 0 ? "R1 rnd" : r == 1 ? "R2 rnd" : r == 2 ? "R3 rnd" : "R4 rnd");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule